// File: doc/BRIEF.md
# Memory Error Log

The block records error events reported by a memory error-checking stage. When the log is empty, the first reported error is captured in full: the failing access address, the kind of error (single-bit or double-bit) and a syndrome value. The syndrome is the failing bit number for a single-bit error. For a double-bit error it is the XOR of the two failing bit numbers. Once the log holds an error, later errors set only a multiple-error flag. Everything else stays frozen until software clears the log.

The log can be read over two independent paths. The first is an I/O register page. Offset 0 returns the captured address and offset 1 returns the status word. A write to offset 3 clears the log. The second is a debug register port. Register 2 returns the address and register 3 returns the 12-bit status word, zero-extended. Both read paths are combinational views of the same stored state.

Top module: `ecclog_top`

## Requirements
- R1: After reset, the captured address and the status word are zero on both read paths.
- R2: When the log is empty, a single-bit error sets status bit 1. The same error places its bit number in the syndrome field (status bits 11:5), clears bit 0 and captures the address.
- R3: When the log is empty, a double-bit error sets status bit 3. The same error places the XOR of the two bit numbers in status bits 11:5, clears bit 0 and captures the address.
- R4: An error arriving while an error is already logged sets status bit 0. It leaves the address, the type bits and the syndrome unchanged. Status bits 2 and 4 always read zero.
- R5: On the I/O path, offset 0 reads the address and offset 1 reads the status. Offsets 2 and 3 read zero.
- R6: On the debug path, register 2 reads the 32-bit address and register 3 reads the 12-bit status, zero-extended. All other register numbers read zero.
- R7: An I/O write to offset 3 clears the address and the status. I/O writes to offsets 0, 1 and 2 have no effect on the log.
- R8: When a clear and an error arrive in the same cycle, the error is logged as a first error and bit 0 stays clear.
- R9: While no error is reported, the bit-number and address inputs have no effect on the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An error is reported this cycle |
| ev_double | input | 1 | The reported error is double-bit (0: single-bit) |
| ev_bit_a | input | 7 | Failing bit number (first bit for double) |
| ev_bit_b | input | 7 | Second failing bit number (double only) |
| ev_addr | input | 32 | Address of the failing access |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 2 | I/O register offset for read and write |
| io_rdata | output | 32 | I/O read data |
| dbg_sel | input | 3 | Debug register number |
| dbg_rdata | output | 32 | Debug read data |

## Verification
Two events can fall in the same cycle: the clear written at I/O offset 3 and a newly reported error. The bench provokes this both with an empty log and with a full log. It expects the new error to appear as a fresh first capture with the multiple flag clear. A reference model compares the result on both read paths each cycle. A second case checks that a clear with no error empties the log, so a later error counts as first again.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;
  localparam int STS_MULT_BIT   = 0;
  localparam int STS_SINGLE_BIT = 1;
  localparam int STS_DOUBLE_BIT = 3;
  localparam int STS_SYN_LSB    = 5;
  localparam int IO_OFS_ADDR    = 0;
  localparam int IO_OFS_STAT    = 1;
  localparam int IO_OFS_CLEAR   = 3;
  localparam int DBG_REG_ADDR   = 2;
  localparam int DBG_REG_STAT   = 3;
endpackage

// File: rtl/ecclog_capture.sv
module ecclog_capture #(
  parameter int ADDR_W = 32,
  parameter int BIT_W  = 7,
  localparam int STAT_W = ecclog_pkg::STS_SYN_LSB + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_double,
  input  logic [BIT_W-1:0]  ev_bit_a,
  input  logic [BIT_W-1:0]  ev_bit_b,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              clr,
  output logic [ADDR_W-1:0] log_addr,
  output logic [STAT_W-1:0] log_status
);
  import ecclog_pkg::*;

  function automatic logic [BIT_W-1:0] syndrome_of(input logic dbl,
                                                   input logic [BIT_W-1:0] a,
                                                   input logic [BIT_W-1:0] b);
    return dbl ? (a ^ b) : a;
  endfunction

  logic             r_single, r_double, r_mult;
  logic [BIT_W-1:0] r_syn;
  logic [ADDR_W-1:0] r_addr;

  logic logged, take_first, take_more;
  assign logged     = r_single | r_double;
  assign take_first = ev_valid && (!logged || clr);
  assign take_more  = ev_valid && logged && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_single <= 1'b0; r_double <= 1'b0; r_mult <= 1'b0;
      r_syn <= '0; r_addr <= '0;
    end else if (take_first) begin
      r_addr   <= ev_addr;
      r_single <= !ev_double;
      r_double <= ev_double;
      r_syn    <= syndrome_of(ev_double, ev_bit_a, ev_bit_b);
      r_mult   <= 1'b0;
    end else if (clr) begin
      r_single <= 1'b0; r_double <= 1'b0; r_mult <= 1'b0;
      r_syn <= '0; r_addr <= '0;
    end else if (take_more) begin
      r_mult <= 1'b1;
    end
  end

  always_comb begin
    log_status = '0;
    log_status[STS_MULT_BIT]   = r_mult;
    log_status[STS_SINGLE_BIT] = r_single;
    log_status[STS_DOUBLE_BIT] = r_double;
    log_status[STS_SYN_LSB +: BIT_W] = r_syn;
  end
  assign log_addr = r_addr;

  // R4: type bits never both set; multiple flag only with a logged error
  assert_type_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({log_status[STS_SINGLE_BIT], log_status[STS_DOUBLE_BIT]}));
  assert_mult_needs_log_R4: assert property (@(posedge clk) disable iff (!rst_n)
    log_status[STS_MULT_BIT] |-> (log_status[STS_SINGLE_BIT] || log_status[STS_DOUBLE_BIT]));
  // R4: a later error freezes address and syndrome, raises the flag
  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_more |=> ($stable(log_addr) && $stable(log_status[STAT_W-1:STS_SYN_LSB])
                   && log_status[STS_MULT_BIT]));
  // R2/R3/R8: a first capture takes the address and leaves the flag clear
  assert_first_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_first |=> (log_addr == $past(ev_addr) && !log_status[STS_MULT_BIT]));
  // R7: a clear with no error empties the log
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev_valid) |=> (log_status == '0 && log_addr == '0));
  // R9: with no event and no clear, nothing moves
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !clr) |=> ($stable(log_status) && $stable(log_addr)));
endmodule

// File: rtl/ecclog_rdport.sv
module ecclog_rdport #(
  parameter int SEL_W    = 2,
  parameter int RD_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int STAT_W   = 12,
  parameter int ADDR_SEL = 0,
  parameter int STAT_SEL = 1
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] log_addr,
  input  logic [STAT_W-1:0] log_status,
  output logic [RD_W-1:0]   rdata
);
  always_comb begin
    rdata = '0;
    if (sel == SEL_W'(ADDR_SEL))      rdata[ADDR_W-1:0] = log_addr;
    else if (sel == SEL_W'(STAT_SEL)) rdata[STAT_W-1:0] = log_status;
  end
endmodule

// File: rtl/ecclog_top.sv
module ecclog_top #(
  parameter int ADDR_W = 32,
  parameter int BIT_W  = 7,
  parameter int RD_W   = 32,
  parameter int IO_W   = 2,
  parameter int DBG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_double,
  input  logic [BIT_W-1:0]  ev_bit_a,
  input  logic [BIT_W-1:0]  ev_bit_b,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              io_wr,
  input  logic [IO_W-1:0]   io_addr,
  output logic [RD_W-1:0]   io_rdata,
  input  logic [DBG_W-1:0]  dbg_sel,
  output logic [RD_W-1:0]   dbg_rdata
);
  import ecclog_pkg::*;
  localparam int STAT_W = STS_SYN_LSB + BIT_W;

  logic              clr;
  logic [ADDR_W-1:0] log_addr;
  logic [STAT_W-1:0] log_status;

  assign clr = io_wr && (io_addr == IO_W'(IO_OFS_CLEAR));

  ecclog_capture #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_double(ev_double),
    .ev_bit_a(ev_bit_a), .ev_bit_b(ev_bit_b), .ev_addr(ev_addr), .clr(clr),
    .log_addr(log_addr), .log_status(log_status));

  ecclog_rdport #(.SEL_W(IO_W), .RD_W(RD_W), .ADDR_W(ADDR_W), .STAT_W(STAT_W),
                  .ADDR_SEL(IO_OFS_ADDR), .STAT_SEL(IO_OFS_STAT)) u_io_rd (
    .sel(io_addr), .log_addr(log_addr), .log_status(log_status), .rdata(io_rdata));

  ecclog_rdport #(.SEL_W(DBG_W), .RD_W(RD_W), .ADDR_W(ADDR_W), .STAT_W(STAT_W),
                  .ADDR_SEL(DBG_REG_ADDR), .STAT_SEL(DBG_REG_STAT)) u_dbg_rd (
    .sel(dbg_sel), .log_addr(log_addr), .log_status(log_status), .rdata(dbg_rdata));

  // R5/R6: both read paths agree on the selected register
  assert_paths_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == IO_W'(IO_OFS_STAT) && dbg_sel == DBG_W'(DBG_REG_STAT)) |-> io_rdata == dbg_rdata);
endmodule

// File: tb/sim_ecclog_top.sv
module sim_ecclog_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 0, ev_double = 0;
  logic [6:0]  ev_bit_a = 0, ev_bit_b = 0;
  logic [31:0] ev_addr = 0;
  logic        io_wr = 0;
  logic [1:0]  io_addr = 0;
  logic [2:0]  dbg_sel = 0;
  logic [31:0] io_rdata, dbg_rdata;

  int checks = 0, fails = 0;
  int cyc = 0;
  // reference model state
  bit  m_has, m_dbl, m_mult;
  int  m_syn;
  int unsigned m_addr;
  int unsigned lcg = 32'h1234_5678;

  ecclog_top u0 (.clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_double(ev_double),
    .ev_bit_a(ev_bit_a), .ev_bit_b(ev_bit_b), .ev_addr(ev_addr), .io_wr(io_wr),
    .io_addr(io_addr), .io_rdata(io_rdata), .dbg_sel(dbg_sel), .dbg_rdata(dbg_rdata));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      fails++;
      $display("FAIL watchdog expired: actual cycle %0d expected done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int unsigned m_status();
    int unsigned s = 0;
    if (m_has) begin
      s = m_dbl ? 8 : 2;
      s = s + (m_syn << 5) + (m_mult ? 1 : 0);
    end
    return s;
  endfunction

  function automatic int unsigned m_read(int sel, bit dbg);
    if (dbg) return sel == 2 ? m_addr : sel == 3 ? m_status() : 0;
    return sel == 0 ? m_addr : sel == 1 ? m_status() : 0;
  endfunction

  task automatic check(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: compare outputs, drive inputs, advance model after the edge
  task automatic step(string req, bit v, bit d, int a, int b, int unsigned ad,
                      bit wr, int ia, int ds);
    @(negedge clk);
    check(req, io_rdata, m_read(io_addr, 0));
    check(req, dbg_rdata, m_read(dbg_sel, 1));
    ev_valid = v; ev_double = d; ev_bit_a = 7'(a); ev_bit_b = 7'(b); ev_addr = ad;
    io_wr = wr; io_addr = 2'(ia); dbg_sel = 3'(ds);
    @(posedge clk);
    #1;
    begin
      bit clr = wr && ia == 3;
      if (v && (!m_has || clr)) begin
        m_has = 1; m_dbl = d; m_mult = 0; m_addr = ad;
        m_syn = d ? ((a ^ b) & 127) : a;
      end else if (clr) begin
        m_has = 0; m_dbl = 0; m_mult = 0; m_syn = 0; m_addr = 0;
      end else if (v) m_mult = 1;
    end
  endtask

  task automatic idle(string req, int ia, int ds);
    step(req, 0, 0, 0, 0, 0, 0, ia, ds);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state on both paths
    idle("R1", 0, 2); idle("R1", 1, 3); idle("R5", 2, 2);
    // R2 single error bit 62, address 0xF0
    step("R2", 1, 0, 62, 0, 32'hF0, 0, 1, 3);
    idle("R2", 0, 2); idle("R2", 1, 3);
    check("R2 status", io_rdata, 32'h7C2);
    // R4 further double error -> status 3 + 62<<5 = 0x7C3
    step("R4", 1, 1, 5, 9, 32'hBAD, 0, 1, 3);
    idle("R4", 1, 2);
    @(negedge clk);
    check("R4 status", io_rdata, 32'h7C3);
    check("R4 address", dbg_rdata, 32'hF0);
    // R9 bit/address inputs without valid
    step("R9", 0, 1, 33, 44, 32'hFFFF_FFFF, 0, 0, 3);
    // R7 writes to offsets 0..2 ignored
    step("R7", 0, 0, 0, 0, 0, 1, 0, 3);
    step("R7", 0, 0, 0, 0, 0, 1, 1, 3);
    step("R7", 0, 0, 0, 0, 0, 1, 2, 3);
    idle("R7", 0, 3);
    // R7 clear
    step("R7", 0, 0, 0, 0, 0, 1, 3, 3);
    idle("R7", 1, 2); idle("R6", 3, 7);
    // R3 double 62,66 -> 8 + 124<<5 = 0xF88
    step("R3", 1, 1, 62, 66, 32'hF0, 0, 1, 3);
    idle("R3", 1, 3);
    @(negedge clk);
    check("R3 status", io_rdata, 32'hF88);
    step("R4", 1, 0, 1, 0, 32'h44, 0, 1, 2);
    idle("R4", 1, 3);
    @(negedge clk);
    check("R4 status", io_rdata, 32'hF89);
    // R8 clear and error together with a full log
    step("R8", 1, 0, 17, 0, 32'h1234, 1, 3, 3);
    idle("R8", 1, 2);
    @(negedge clk);
    check("R8 status", io_rdata, 32'h222);
    // R8 clear and error together with an empty log
    step("R7", 0, 0, 0, 0, 0, 1, 3, 3);
    step("R8", 1, 1, 3, 4, 32'h55, 1, 3, 3);
    idle("R8", 1, 2);
    // mixed patterns, all requirements
    for (int i = 0; i < 400; i++) begin
      lcg = lcg * 1103515245 + 12345;
      step("R2 R3 R4 R7 R8 R9", lcg[17:16] == 0, lcg[18], int'(lcg[26:20]), int'(lcg[13:7]),
           lcg ^ 32'hA5A5_0000, lcg[29:28] == 0, int'(lcg[31:30]), int'(lcg[3:1]));
    end
    idle("R5", 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule